// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block issues operand addresses for indirect memory accesses. It holds a set of address pointers. Each pointer has its own ring length and its own ring base. It also holds a separate set of signed step values. When an access is requested, the block presents the chosen pointer's current value as the address on the next clock. It then advances that pointer by the chosen step. If the pointer's length is nonzero, the result is folded back into the ring that starts at the pointer's base. If the length is zero, the pointer moves linearly modulo 2^AW.

A register port loads pointers, steps and lengths. Loading a pointer also loads its ring base with the same value, so a buffer is placed by writing its start address. A registered read port returns any register, including the base, which cannot be written directly. Two instances can run side by side, one per memory space. Each instance sustains one access per clock.

Top module: `circ_dag`

## Requirements
- R1: After synchronous reset, `addr_out`, `addr_vld` and `rd_data` are zero, and every pointer, step, length and base reads back as zero.
- R2: An access in cycle t drives `addr_out` in cycle t+1 with the selected pointer's value before its update, and `addr_vld` is high in t+1 exactly when an access was requested in t. Without an access, `addr_out` holds and the pointer is unchanged.
- R3: With length zero, the pointer becomes (pointer + step) modulo 2^14. For example, 16380 stepped by 4 gives 0.
- R4: Step values are 14-bit two's complement, so a step of 0x3FFD moves a pointer back by 3.
- R5: With length L nonzero and base B, a post-modified value of B+L or above is reduced by L.
- R6: With length L nonzero and base B, a post-modified value below B is increased by L.
- R7: `wr_bank` encodes 00 pointer, 01 step, 10 length, 11 base. A pointer write sets both the pointer and its base to `wr_data`.
- R8: A pointer write and an access to the same pointer in one cycle leave the written value in the pointer. The issued address is still the old value.
- R9: `rd_data` in cycle t+1 equals the register selected by `rd_bank`/`rd_idx` as it stood in cycle t, before any write in cycle t.
- R10: A write with `wr_bank` = 11 changes no register.
- R11: Accesses on consecutive cycles, to the same or different pointers, each update their pointer without a stall.
- R12: Any step register can be used with any pointer. A step write in the same cycle as an access uses the old step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_mod | input | 2 | Step register used by the access |
| addr_out | output | 14 | Registered issued address |
| addr_vld | output | 1 | Address valid, one cycle after the request |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Register bank for the write |
| wr_idx | input | 2 | Register index for the write |
| wr_data | input | 14 | Write data |
| rd_bank | input | 2 | Register bank for readback |
| rd_idx | input | 2 | Register index for readback |
| rd_data | output | 14 | Registered readback data |

## Verification
The hardest case to reach is a ring fold that meets another event in the same cycle. Examples are a pointer write colliding with an access to that pointer, or a step write arriving just as that step is used. The stimulus reaches these with a directed sequence. Pointers are placed next to their ring ends and near the top of the address space. Forward and backward steps then run across each boundary. Deliberate same-cycle collisions follow. After that, a long random run keeps every ring length at least as large as any step, which makes folds frequent. The behavioural reference is compared on every clock.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    BANK_PTR  = 2'b00,
    BANK_MOD  = 2'b01,
    BANK_LEN  = 2'b10,
    BANK_BASE = 2'b11
  } bank_e;
endpackage

// File: rtl/dag_wrap_unit.sv
module dag_wrap_unit #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] nxt_o
);
  localparam int W = AW + 2;

  logic signed [W-1:0] sum;
  logic signed [W-1:0] lo;
  logic signed [W-1:0] hi;
  logic signed [W-1:0] len_s;
  logic signed [W-1:0] fixed;
  logic [W-AW-1:0]     fixed_unused_hi;

  always_comb begin
    sum   = $signed({2'b00, ptr_i}) + $signed({{2{mod_i[AW-1]}}, mod_i});
    lo    = $signed({2'b00, base_i});
    len_s = $signed({2'b00, len_i});
    hi    = lo + len_s;
    fixed = sum;
    if (len_i != '0) begin
      if (sum >= hi)
        fixed = sum - len_s;
      else if (sum < lo)
        fixed = sum + len_s;
    end
  end

  assign nxt_o           = fixed[AW-1:0];
  assign fixed_unused_hi = fixed[W-1:AW];
endmodule

// File: rtl/dag_mod_bank.sv
module dag_mod_bank #(
  parameter int N  = 4,
  parameter int AW = 14,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [IW-1:0] aidx_i,
  output logic [AW-1:0] adata_o,
  input  logic [IW-1:0] ridx_i,
  output logic [AW-1:0] rdata_o
);
  logic [AW-1:0] steps [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) steps[i] <= '0;
    end else if (we_i) begin
      steps[widx_i] <= wdata_i;
    end
  end

  assign adata_o = steps[aidx_i];
  assign rdata_o = steps[ridx_i];
endmodule

// File: rtl/dag_ptr_slice.sv
module dag_ptr_slice #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_i,
  input  logic [AW-1:0] mod_i,
  input  logic          wr_ptr_i,
  input  logic          wr_len_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] len_o
);
  logic [AW-1:0] ptr_q, base_q, len_q, nxt;

  dag_wrap_unit #(.AW(AW)) u_wrap (
    .ptr_i (ptr_q),
    .mod_i (mod_i),
    .base_i(base_q),
    .len_i (len_q),
    .nxt_o (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (wr_ptr_i) begin
        ptr_q  <= wdata_i;
        base_q <= wdata_i;
      end else if (upd_i) begin
        ptr_q <= nxt;
      end
      if (wr_len_i) len_q <= wdata_i;
    end
  end

  assign ptr_o  = ptr_q;
  assign base_o = base_q;
  assign len_o  = len_q;
endmodule

// File: rtl/circ_dag.sv
module circ_dag #(
  parameter int NUM_PTR = 4,
  parameter int NUM_MOD = 4,
  parameter int AW      = 14,
  localparam int PW = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
  localparam int MW = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1,
  localparam int IW = (PW > MW) ? PW : MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic [PW-1:0] acc_ptr,
  input  logic [MW-1:0] acc_mod,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld,
  input  logic          wr_en,
  input  logic [1:0]    wr_bank,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_bank,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);
  import dag_pkg::*;

  logic [NUM_PTR-1:0][AW-1:0] ptr_v;
  logic [NUM_PTR-1:0][AW-1:0] base_v;
  logic [NUM_PTR-1:0][AW-1:0] len_v;
  logic [AW-1:0] acc_step, rd_step, rd_nxt;
  logic [AW-1:0] addr_q, rd_q;
  logic          vld_q;
  bank_e         wbank, rbank;

  assign wbank = bank_e'(wr_bank);
  assign rbank = bank_e'(rd_bank);

  dag_mod_bank #(.N(NUM_MOD), .AW(AW)) u_steps (
    .clk    (clk),
    .rst    (rst),
    .we_i   (wr_en && wbank == BANK_MOD),
    .widx_i (wr_idx[MW-1:0]),
    .wdata_i(wr_data),
    .aidx_i (acc_mod),
    .adata_o(acc_step),
    .ridx_i (rd_idx[MW-1:0]),
    .rdata_o(rd_step)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    dag_ptr_slice #(.AW(AW)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .upd_i   (acc_en && acc_ptr == PW'(g)),
      .mod_i   (acc_step),
      .wr_ptr_i(wr_en && wbank == BANK_PTR && wr_idx == IW'(g)),
      .wr_len_i(wr_en && wbank == BANK_LEN && wr_idx == IW'(g)),
      .wdata_i (wr_data),
      .ptr_o   (ptr_v[g]),
      .base_o  (base_v[g]),
      .len_o   (len_v[g])
    );
  end

  always_comb begin
    unique case (rbank)
      BANK_PTR:  rd_nxt = ptr_v[rd_idx[PW-1:0]];
      BANK_MOD:  rd_nxt = rd_step;
      BANK_LEN:  rd_nxt = len_v[rd_idx[PW-1:0]];
      default:   rd_nxt = base_v[rd_idx[PW-1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      vld_q <= acc_en;
      if (acc_en) addr_q <= ptr_v[acc_ptr];
      rd_q <= rd_nxt;
    end
  end

  assign addr_out = addr_q;
  assign addr_vld = vld_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int NUM_PTR = 4,
  parameter int AW      = 14,
  parameter int PW      = 2,
  parameter int IW      = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       acc_en,
  input logic [PW-1:0]              acc_ptr,
  input logic                       wr_en,
  input logic [1:0]                 wr_bank,
  input logic [IW-1:0]              wr_idx,
  input logic [AW-1:0]              wr_data,
  input logic                       addr_vld,
  input logic [NUM_PTR-1:0][AW-1:0] ptr_v,
  input logic [NUM_PTR-1:0][AW-1:0] base_v
);
  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !addr_vld);

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_k
    // R8
    ptr_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_bank == 2'b00 && wr_idx == IW'(k)) |=> ptr_v[k] == $past(wr_data));

    // R7
    base_follows_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_bank == 2'b00 && wr_idx == IW'(k)) |=> base_v[k] == $past(wr_data));

    // R10
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_bank == 2'b00 && wr_idx == IW'(k)) |=> $stable(base_v[k]));

    // R2
    ptr_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!(acc_en && acc_ptr == PW'(k)) && !(wr_en && wr_bank == 2'b00 && wr_idx == IW'(k)))
      |=> $stable(ptr_v[k]));
  end
endmodule

bind circ_dag dag_chk #(.NUM_PTR(NUM_PTR), .AW(AW), .PW(PW), .IW(IW)) u_dag_chk (
  .clk     (clk),
  .rst     (rst),
  .acc_en  (acc_en),
  .acc_ptr (acc_ptr),
  .wr_en   (wr_en),
  .wr_bank (wr_bank),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .addr_vld(addr_vld),
  .ptr_v   (ptr_v),
  .base_v  (base_v)
);

// File: tb/test_circ_dag.sv
module test_circ_dag;
  localparam int MASK = 16'h3FFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic [1:0]  acc_ptr = '0, acc_mod = '0;
  logic [13:0] addr_out;
  logic        addr_vld;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_bank = '0, wr_idx = '0, rd_bank = '0, rd_idx = '0;
  logic [13:0] wr_data = '0;
  logic [13:0] rd_data;

  int compared = 0, mismatched = 0;
  int mp[4], mb[4], ml[4], mm[4];
  int exp_addr = 0, exp_vld = 0, exp_rd = 0;
  bit done = 0;

  circ_dag i_circ_dag (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
    .addr_out(addr_out), .addr_vld(addr_vld), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_bank(rd_bank), .rd_idx(rd_idx),
    .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int next_ptr(int p, int m, int b, int l);
    int s = p + m;
    if (l != 0) begin
      if (s >= b + l) s = s - l;
      else if (s < b) s = s + l;
    end
    return s & MASK;
  endfunction

  task automatic step(string tag, bit acc, int p, int m, bit we, int bank,
                      int widx, int wdata, int rbank, int ridx);
    acc_en = acc; acc_ptr = 2'(p); acc_mod = 2'(m);
    wr_en = we; wr_bank = 2'(bank); wr_idx = 2'(widx); wr_data = 14'(wdata);
    rd_bank = 2'(rbank); rd_idx = 2'(ridx);
    case (rbank)
      0: exp_rd = mp[ridx];
      1: exp_rd = mm[ridx] & MASK;
      2: exp_rd = ml[ridx];
      default: exp_rd = mb[ridx];
    endcase
    exp_vld = acc;
    if (acc) begin
      exp_addr = mp[p];
      mp[p] = next_ptr(mp[p], mm[m], mb[p], ml[p]);
    end
    if (we) begin
      case (bank)
        0: begin mp[widx] = wdata & MASK; mb[widx] = wdata & MASK; end
        1: mm[widx] = ((wdata & MASK) >= 8192) ? (wdata & MASK) - 16384 : (wdata & MASK);
        2: ml[widx] = wdata & MASK;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "addr_out", int'(addr_out), exp_addr);
    check(tag, "addr_vld", int'(addr_vld), exp_vld);
    check(tag, "rd_data", int'(rd_data), exp_rd);
  endtask

  task automatic wr(string tag, int bank, int idx, int val);
    step(tag, 0, 0, 0, 1, bank, idx, val & MASK, bank, idx);
  endtask

  task automatic acc(string tag, int p, int m);
    step(tag, 1, p, m, 0, 0, 0, 0, 0, p);
  endtask

  task automatic rd(string tag, int bank, int idx);
    step(tag, 0, 0, 0, 0, 0, 0, 0, bank, idx);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mp[i] = 0; mb[i] = 0; ml[i] = 0; mm[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs zero while in reset
    check("R1", "addr_out", int'(addr_out), 0);
    check("R1", "addr_vld", int'(addr_vld), 0);
    check("R1", "rd_data", int'(rd_data), 0);
    rst = 1'b0;
    // R1: every register reads back zero
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 4; i++) rd("R1", b, i);

    // R7 / R9: pointer write also places the base
    wr("R7", 0, 0, 100);
    rd("R9", 0, 0);
    rd("R7", 3, 0);
    wr("R12", 1, 0, 4);
    wr("R4", 1, 1, -3);
    wr("R12", 1, 2, 1);
    wr("R12", 1, 3, 2);
    wr("R5", 2, 0, 10);
    // R5: forward fold in ring 100..109
    for (int i = 0; i < 5; i++) acc("R5", 0, 0);
    // R6: backward fold in ring 50..57
    wr("R6", 0, 1, 50);
    wr("R6", 2, 1, 8);
    for (int i = 0; i < 4; i++) acc("R6", 1, 1);
    // R3: linear wrap at top of space
    wr("R3", 0, 2, 16380);
    for (int i = 0; i < 3; i++) acc("R3", 2, 0);
    // R4: negative step below zero
    wr("R4", 0, 3, 5);
    for (int i = 0; i < 3; i++) acc("R4", 3, 1);
    // R8: write and access to same pointer
    step("R8", 1, 0, 0, 1, 0, 0, 200, 0, 0);
    acc("R8", 0, 0);
    rd("R8", 0, 0);
    // R12: step write colliding with its use
    step("R12", 1, 2, 2, 1, 1, 2, 5, 1, 2);
    acc("R12", 2, 2);
    acc("R12", 2, 3);
    // R10: base bank write ignored
    wr("R10", 3, 1, 999);
    rd("R10", 3, 1);
    rd("R10", 0, 1);
    // R11: back-to-back on mixed pointers
    for (int i = 0; i < 8; i++) acc("R11", i % 4, (i + 1) % 4);

    // R11: random run, rings no shorter than any step
    for (int n = 0; n < 3000; n++) begin
      bit a = ($urandom_range(0, 9) < 7);
      bit w = ($urandom_range(0, 9) < 2);
      int bank = $urandom_range(0, 3);
      int val;
      case (bank)
        0: val = $urandom_range(0, 16000);
        1: val = $urandom_range(0, 14) - 7;
        2: val = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(8, 40);
        default: val = $urandom_range(0, 16383);
      endcase
      step("R11", a, $urandom_range(0, 3), $urandom_range(0, 3), w, bank,
           $urandom_range(0, 3), val & MASK, $urandom_range(0, 3), $urandom_range(0, 3));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule